// File: doc/BRIEF.md
# Biphase-Mark Audio Frame Transmitter

This block turns a stream of audio samples into the serial line of a consumer digital audio link. Every frame carries a left and a right subframe. Each subframe is 32 time slots long. The first four slots hold a synchronisation preamble. The next 24 slots carry the audio word, least significant bit first. Then come a validity flag, a user bit, a channel-status bit and an even-parity bit. All slots except the preamble are sent with biphase-mark coding, using two half-bit cells per slot. Every 192 frames form a block, and the first frame of each block gets its own preamble.

Samples arrive over a valid/ready handshake and pass through a one-entry holding stage. The line rate comes from a divider on the master audio clock. The divider uses a 5-bit ratio setting, and the effective divide value is the setting plus one. The sample width can be 16, 20 or 24 bits. A mono mode repeats one sample in both subframes. A raw-data mode marks the stream as not carrying linear audio. A neighbouring block supplies one channel-status bit per frame, and it chooses that bit by the frame index this block puts out.

Top module: `audio_bmc_tx`

## Requirements
- R1: The block runs only while `glob_en` and `tx_en` are both high. In any cycle where either is low, the next cycle shows `bmc_out` at 0, `smp_ready` at 0 and `frame_idx` at 0. The next run starts again with the left subframe of frame 0.
- R2: Each half-bit cell lasts `ratio_cfg`+1 clock cycles. The first cell of a run appears on `bmc_out` after the (`ratio_cfg`+1)-th rising edge that sees the block enabled.
- R3: Slots 4 to 31 each take two cells. The line level changes at the start of every slot, and changes again in the middle of the slot only when the slot's bit is 1.
- R4: The first 8 cells of a subframe equal a pattern XOR the line level just before the subframe, with the leftmost pattern bit sent first. The pattern is 11101000 for the left subframe of frame 0 of each 192-frame block, 11100010 for every other left subframe, and 11100100 for every right subframe.
- R5: Slots 4 to 27 carry the 24-bit audio field, least significant bit first. Slot 28 is validity, slot 29 is the user bit (always 0), slot 30 is channel status and slot 31 is parity. Slots 4 to 31 together always hold an even number of ones.
- R6: `fmt_cfg` 0 takes `smp_data[15:0]` and `fmt_cfg` 1 takes `smp_data[19:0]`. Each is left-justified into the 24-bit audio field, with the low bits set to zero. `fmt_cfg` 2 uses all 24 bits, and the reserved code 3 behaves like 2.
- R7: In stereo mode (`mono_cfg`=0) each subframe uses its own sample, left first, in the order the samples were accepted. In mono mode one sample per frame goes into both subframes.
- R8: The validity slot is 1 while `raw_cfg` is high and 0 otherwise.
- R9: `frame_idx` shows the number of the frame being sent, counting 0 to 191. The block samples `cs_bit` at the clock edge that starts a left subframe, and sends that value in both subframes of the frame.
- R10: A sample is accepted on a rising edge where `smp_valid` and `smp_ready` are both high. If a subframe that needs a sample starts when none is held or offered, its audio field is zero. Acceptance and use in the same cycle keep the samples in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit enable |
| ratio_cfg | input | 5 | Cell length in clocks, minus one |
| fmt_cfg | input | 2 | Sample width code: 0 = 16, 1 = 20, 2 or 3 = 24 bits |
| mono_cfg | input | 1 | One sample feeds both subframes |
| raw_cfg | input | 1 | Mark stream as non-audio data (validity = 1) |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample can be taken this cycle |
| smp_data | input | 24 | Sample, right-aligned |
| cs_bit | input | 1 | Channel-status bit for the frame named by `frame_idx` |
| frame_idx | output | 8 | Index of the frame in its 192-frame block |
| bmc_out | output | 1 | Biphase-mark coded line |

## Verification
Two things can land on the same rising edge: the holding stage accepts a new sample, and the start of a subframe removes the held sample. The same applies when the holding stage is empty and the offered sample goes straight through into the subframe. The bench keeps `smp_valid` high without a break, so every subframe start also takes in a new sample. It also leaves `smp_valid` low for several subframes to drain the stage, then raises it again. Each decoded audio field is compared with a model queue. The model pushes at every handshake and pops at every edge that starts a subframe, so a lost, doubled or reordered sample shows up as a wrong field.

// File: rtl/bmc_tx_pkg.sv
`timescale 1ns/1ps
package bmc_tx_pkg;
  localparam int AUDIO_W   = 24;
  localparam int SF_BITS   = 32;
  localparam int PRE_CELLS = 8;

  typedef enum logic [1:0] {
    FMT_W16 = 2'd0,
    FMT_W20 = 2'd1,
    FMT_W24 = 2'd2,
    FMT_RSV = 2'd3
  } smp_fmt_e;

  typedef enum logic [1:0] {
    PRE_BLOCK = 2'd0,
    PRE_LEFT  = 2'd1,
    PRE_RIGHT = 2'd2
  } pre_kind_e;

  // place a right-aligned sample at the top of the audio field
  function automatic logic [AUDIO_W-1:0] justify_sample(input logic [AUDIO_W-1:0] d,
                                                        input logic [1:0] fmt);
    logic [AUDIO_W-1:0] r;
    case (fmt)
      FMT_W16: r = {d[15:0], 8'h00};
      FMT_W20: r = {d[19:0], 4'h0};
      default: r = d;
    endcase
    return r;
  endfunction

  // cell pattern of the sync slots, leftmost cell first, relative to entry level
  function automatic logic [PRE_CELLS-1:0] pre_pattern(input pre_kind_e k);
    logic [PRE_CELLS-1:0] p;
    case (k)
      PRE_BLOCK: p = 8'b1110_1000;
      PRE_LEFT:  p = 8'b1110_0010;
      default:   p = 8'b1110_0100;
    endcase
    return p;
  endfunction

  // assemble the 32 slots of one subframe; slot 31 evens out slots 4..31
  function automatic logic [SF_BITS-1:0] build_subframe(input logic [AUDIO_W-1:0] audio,
                                                        input logic v,
                                                        input logic u,
                                                        input logic c);
    logic [SF_BITS-1:0] w;
    w        = '0;
    w[27:4]  = audio;
    w[28]    = v;
    w[29]    = u;
    w[30]    = c;
    w[31]    = ^w[30:4];
    return w;
  endfunction
endpackage

// File: rtl/bmc_clk_div.sv
`timescale 1ns/1ps
module bmc_clk_div #(
  parameter int RATIO_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  logic [RATIO_W-1:0] cnt_q;
  logic               at_end;

  assign at_end = (cnt_q >= ratio);
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (at_end) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // a cell of more than one clock never yields back-to-back ticks
  assert_cell_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio != '0) |=> (!tick || !$stable(ratio)));
endmodule

// File: rtl/bmc_sample_stage.sv
`timescale 1ns/1ps
module bmc_sample_stage #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              take,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              smp_ready,
  output logic              out_avail,
  output logic [DATA_W-1:0] out_data
);
  logic              hold_full_q;
  logic [DATA_W-1:0] hold_data_q;
  logic              accept;

  assign smp_ready = run && (!hold_full_q || take);
  assign accept    = smp_valid && smp_ready;
  assign out_avail = hold_full_q || accept;
  assign out_data  = hold_full_q ? hold_data_q : smp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full_q <= 1'b0;
      hold_data_q <= '0;
    end else if (!run) begin
      hold_full_q <= 1'b0;
    end else if (take) begin
      // held word leaves; a new one refills only if the old one was there
      if (hold_full_q && accept) begin
        hold_data_q <= smp_data;
        hold_full_q <= 1'b1;
      end else begin
        hold_full_q <= 1'b0;
      end
    end else if (accept) begin
      hold_data_q <= smp_data;
      hold_full_q <= 1'b1;
    end
  end

  assert_accept_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !take) |=> hold_full_q);
  assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full_q && smp_valid && smp_ready) |-> take);
endmodule

// File: rtl/bmc_subframe_seq.sv
`timescale 1ns/1ps
module bmc_subframe_seq
  import bmc_tx_pkg::*;
#(
  parameter int FRAMES = 192,
  parameter int FIDX_W = $clog2(FRAMES),
  parameter int CELL_W = $clog2(2 * SF_BITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic [1:0]         fmt,
  input  logic               mono,
  input  logic               raw,
  input  logic               cs_bit,
  input  logic               smp_avail,
  input  logic [AUDIO_W-1:0] smp_data,
  output logic               take,
  output logic [FIDX_W-1:0]  frame_idx,
  output logic [CELL_W-1:0]  cell_cnt,
  output logic               data_bit,
  output logic [PRE_CELLS-1:0] pattern
);
  localparam int LAST_CELL = 2 * SF_BITS - 1;

  logic [CELL_W-1:0]  cell_q;
  logic               right_q;
  logic [FIDX_W-1:0]  frame_q;
  logic [AUDIO_W-1:0] cur_audio_q;
  logic               cs_hold_q;
  logic [SF_BITS-1:0] sf_word_q;

  logic               sf_start;
  logic               sf_end;
  logic [AUDIO_W-1:0] audio_sel;
  logic               c_sel;
  pre_kind_e          kind;

  assign sf_start  = tick && (cell_q == '0);
  assign sf_end    = tick && (cell_q == CELL_W'(LAST_CELL));
  assign take      = sf_start && (!right_q || !mono);
  assign audio_sel = take ? (smp_avail ? justify_sample(smp_data, fmt) : '0) : cur_audio_q;
  assign c_sel     = right_q ? cs_hold_q : cs_bit;
  assign kind      = right_q ? PRE_RIGHT : ((frame_q == '0) ? PRE_BLOCK : PRE_LEFT);
  assign pattern   = pre_pattern(kind);
  assign data_bit  = sf_word_q[cell_q[CELL_W-1:1]];
  assign frame_idx = frame_q;
  assign cell_cnt  = cell_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q      <= '0;
      right_q     <= 1'b0;
      frame_q     <= '0;
      cur_audio_q <= '0;
      cs_hold_q   <= 1'b0;
      sf_word_q   <= '0;
    end else if (!run) begin
      cell_q      <= '0;
      right_q     <= 1'b0;
      frame_q     <= '0;
      cur_audio_q <= '0;
      cs_hold_q   <= 1'b0;
      sf_word_q   <= '0;
    end else if (tick) begin
      cell_q <= cell_q + 1'b1;
      if (sf_start) begin
        sf_word_q   <= build_subframe(audio_sel, raw, 1'b0, c_sel);
        cur_audio_q <= audio_sel;
        if (!right_q) cs_hold_q <= cs_bit;
      end
      if (sf_end) begin
        right_q <= ~right_q;
        if (right_q)
          frame_q <= (frame_q == FIDX_W'(FRAMES - 1)) ? '0 : frame_q + 1'b1;
      end
    end
  end

  assert_even_slots_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cell_q == CELL_W'(1)) |-> (^sf_word_q[31:4] == 1'b0));
  assert_frame_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q <= FIDX_W'(FRAMES - 1));
  assert_cs_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && right_q && cell_q == CELL_W'(1) && $past(run)) |-> (sf_word_q[30] == cs_hold_q));
endmodule

// File: rtl/bmc_line_enc.sv
`timescale 1ns/1ps
module bmc_line_enc
  import bmc_tx_pkg::*;
#(
  parameter int CELL_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 tick,
  input  logic [CELL_W-1:0]    cell_cnt,
  input  logic [PRE_CELLS-1:0] pattern,
  input  logic                 data_bit,
  output logic                 line
);
  logic line_q;
  logic base_q;

  assign line = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      base_q <= 1'b0;
    end else if (!run) begin
      line_q <= 1'b0;
      base_q <= 1'b0;
    end else if (tick) begin
      if (cell_cnt == '0) begin
        base_q <= line_q;
        line_q <= line_q ^ pattern[PRE_CELLS-1];
      end else if (cell_cnt < CELL_W'(PRE_CELLS)) begin
        line_q <= base_q ^ pattern[~cell_cnt[2:0]];
      end else if (!cell_cnt[0]) begin
        line_q <= ~line_q;
      end else begin
        line_q <= line_q ^ data_bit;
      end
    end
  end

  assert_slot_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cell_cnt >= CELL_W'(PRE_CELLS) && !cell_cnt[0]) |=> (line_q != $past(line_q)));
  assert_sync_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cell_cnt == CELL_W'(PRE_CELLS - 1)) |=> (line_q == base_q));
endmodule

// File: rtl/audio_bmc_tx.sv
`timescale 1ns/1ps
module audio_bmc_tx
  import bmc_tx_pkg::*;
#(
  parameter int RATIO_W = 5,
  parameter int FRAMES  = 192,
  parameter int FIDX_W  = $clog2(FRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glob_en,
  input  logic               tx_en,
  input  logic [RATIO_W-1:0] ratio_cfg,
  input  logic [1:0]         fmt_cfg,
  input  logic               mono_cfg,
  input  logic               raw_cfg,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic [AUDIO_W-1:0] smp_data,
  input  logic               cs_bit,
  output logic [FIDX_W-1:0]  frame_idx,
  output logic               bmc_out
);
  localparam int CELL_W = $clog2(2 * SF_BITS);

  logic                 run;
  logic                 tick;
  logic                 take;
  logic                 smp_avail;
  logic [AUDIO_W-1:0]   stage_data;
  logic [CELL_W-1:0]    cell_cnt;
  logic                 data_bit;
  logic [PRE_CELLS-1:0] pattern;

  assign run = glob_en && tx_en;

  bmc_clk_div #(.RATIO_W(RATIO_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .ratio (ratio_cfg),
    .tick  (tick)
  );

  bmc_sample_stage #(.DATA_W(AUDIO_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .take      (take),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .smp_ready (smp_ready),
    .out_avail (smp_avail),
    .out_data  (stage_data)
  );

  bmc_subframe_seq #(.FRAMES(FRAMES), .FIDX_W(FIDX_W), .CELL_W(CELL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .fmt       (fmt_cfg),
    .mono      (mono_cfg),
    .raw       (raw_cfg),
    .cs_bit    (cs_bit),
    .smp_avail (smp_avail),
    .smp_data  (stage_data),
    .take      (take),
    .frame_idx (frame_idx),
    .cell_cnt  (cell_cnt),
    .data_bit  (data_bit),
    .pattern   (pattern)
  );

  bmc_line_enc #(.CELL_W(CELL_W)) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick),
    .cell_cnt (cell_cnt),
    .pattern  (pattern),
    .data_bit (data_bit),
    .line     (bmc_out)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!bmc_out && frame_idx == '0));
endmodule

// File: tb/audio_bmc_tx_tb.sv
`timescale 1ns/1ps
module audio_bmc_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glob_en = 1'b0;
  logic        tx_en = 1'b0;
  logic [4:0]  ratio_cfg = '0;
  logic [1:0]  fmt_cfg = '0;
  logic        mono_cfg = 1'b0;
  logic        raw_cfg = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [23:0] smp_data = '0;
  logic        cs_bit;
  logic [7:0]  frame_idx;
  logic        bmc_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit feed_on = 1'b0;
  bit hs_prev = 1'b0;
  int seq_no = 0;
  logic [23:0] q[$];

  always #2.5 clk = ~clk;

  audio_bmc_tx u_dut (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .tx_en(tx_en),
    .ratio_cfg(ratio_cfg), .fmt_cfg(fmt_cfg), .mono_cfg(mono_cfg), .raw_cfg(raw_cfg),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .cs_bit(cs_bit), .frame_idx(frame_idx), .bmc_out(bmc_out)
  );

  function automatic logic cs_of(input int k);
    return k[0] ^ k[2] ^ k[5];
  endfunction

  assign cs_bit = cs_of(int'(frame_idx));

  function automatic logic [23:0] gen(input int n);
    logic [31:0] x;
    x = n * 32'h0009_E3B5 ^ 32'h00A5_C35A;
    return x[23:0];
  endfunction

  function automatic logic [23:0] expect_audio(input logic [23:0] d, input int fmt);
    int w;
    w = (fmt == 0) ? 16 : (fmt == 1) ? 20 : 24;
    return d << (24 - w);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // sample source: decides at negedge+1 whether the coming edge hands a word over
  always @(negedge clk) begin
    #1;
    if (hs_prev) begin
      seq_no++;
      smp_data = gen(seq_no);
    end
    smp_valid = feed_on;
    hs_prev = smp_valid && smp_ready && rst_n;
    if (hs_prev) q.push_back(smp_data);
  end

  task automatic run_phase(input int r, input int fmt, input bit mono, input bit raw,
                           input int nsf, input string tag, input int off_at, input int on_at);
    logic        cells[64];
    logic [31:0] bits;
    logic [23:0] held;
    logic [7:0]  pat;
    logic        lv, early, prev, pre_ok, bmc_ok, time_ok;
    int          k;
    bit          right;
    @(negedge clk);
    ratio_cfg = 5'(r); fmt_cfg = 2'(fmt); mono_cfg = mono; raw_cfg = raw;
    feed_on = 1'b1;
    glob_en = 1'b1; tx_en = 1'b1;
    lv = 1'b0; k = 0; held = '0;
    for (int sf = 0; sf < nsf; sf++) begin
      right = sf[0];
      time_ok = 1'b1;
      prev = lv;
      for (int c = 0; c < 64; c++) begin
        repeat (r) @(posedge clk);
        #1 early = bmc_out;
        if (r > 0 && early !== prev) time_ok = 1'b0;
        @(posedge clk);
        #1 cells[c] = bmc_out;
        prev = cells[c];
        if (c == 0) begin
          if (!right)
            check(frame_idx == 8'(k % 192), "R9", "frame index", frame_idx, k % 192);
          if (!right || !mono) held = (q.size() > 0) ? q.pop_front() : 24'h0;
          if (sf == off_at) feed_on = 1'b0;
          if (sf == on_at)  feed_on = 1'b1;
        end
      end
      check(time_ok, "R2", "cell held for ratio+1 clocks", time_ok, 1);
      pat = right ? 8'b1110_0100 : ((k % 192 == 0) ? 8'b1110_1000 : 8'b1110_0010);
      pre_ok = 1'b1;
      for (int i = 0; i < 8; i++) if (cells[i] !== (lv ^ pat[7-i])) pre_ok = 1'b0;
      check(pre_ok, "R4", "sync cells", {cells[0],cells[1],cells[2],cells[3],
                                         cells[4],cells[5],cells[6],cells[7]}, pat ^ {8{lv}});
      bmc_ok = 1'b1;
      bits = '0;
      for (int b = 4; b < 32; b++) begin
        if (cells[2*b] === cells[2*b-1]) bmc_ok = 1'b0;
        bits[b] = cells[2*b] ^ cells[2*b+1];
      end
      check(bmc_ok, "R3", "level change at slot start", bmc_ok, 1);
      check(bits[27:4] == expect_audio(held, fmt), tag, "audio field",
            bits[27:4], expect_audio(held, fmt));
      check(bits[28] == raw, "R8", "validity slot", bits[28], raw);
      check(bits[30] == cs_of(k % 192), "R9", "channel status slot", bits[30], cs_of(k % 192));
      check(bits[29] == 1'b0 && (^bits[31:4]) == 1'b0, "R5", "user and parity",
            bits[31:28], {^bits[30:4], bits[30], 1'b0, bits[28]});
      lv = cells[63];
      if (right) k++;
    end
    @(negedge clk);
    tx_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(bmc_out == 1'b0 && smp_ready == 1'b0 && frame_idx == 8'd0, "R1", "idle after disable",
          {bmc_out, smp_ready, frame_idx}, 0);
    q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual %0d expected below %0d", 200000, 200000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit quiet;
    repeat (4) @(posedge clk);
    #1;
    check(bmc_out == 1'b0 && smp_ready == 1'b0 && frame_idx == 8'd0, "R1", "reset state",
          {bmc_out, smp_ready, frame_idx}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    feed_on = 1'b1;

    // one enable alone keeps the line and the handshake quiet (R1)
    glob_en = 1'b1; tx_en = 1'b0;
    quiet = 1'b1;
    repeat (60) begin @(negedge clk); if (bmc_out || smp_ready) quiet = 1'b0; end
    check(quiet, "R1", "global enable only", quiet, 1);
    glob_en = 1'b0; tx_en = 1'b1;
    quiet = 1'b1;
    repeat (60) begin @(negedge clk); if (bmc_out || smp_ready) quiet = 1'b0; end
    check(quiet, "R1", "transmit enable only", quiet, 1);
    tx_en = 1'b0;
    repeat (3) @(posedge clk);
    q.delete();

    // full block plus wrap: stereo, 24-bit, divide by 1 (R4, R7, R9)
    run_phase(0, 2, 1'b0, 1'b0, 388, "R7", -1, -1);
    // mono, 16-bit, raw data, divide by 4 (R6, R7, R8)
    run_phase(3, 0, 1'b1, 1'b1, 16, "R7", -1, -1);
    // stereo, 20-bit, divide by 8 (R2, R6)
    run_phase(7, 1, 1'b0, 1'b0, 8, "R6", -1, -1);
    // reserved width code behaves as 24-bit, divide by 2 (R6)
    run_phase(1, 3, 1'b0, 1'b1, 8, "R6", -1, -1);
    // longest cell, mono 24-bit (R2, R7)
    run_phase(31, 2, 1'b1, 1'b0, 2, "R7", -1, -1);
    // starve the holding stage, then refill (R10)
    run_phase(0, 2, 1'b0, 1'b0, 22, "R10", 4, 12);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule